// File: doc/BRIEF.md
# SPI Serial EEPROM Slave (128 x 8)

This block is a synthesizable behavioural model of a small serial EEPROM. It holds 128 bytes and responds only as a slave on a four-wire SPI bus. It also has an active-low write-protect pin and an active-low hold pin. The bus pins are sampled by the block's own system clock, and SCK edges are found by oversampling. For this reason the bus clock must stay at least four system clocks in each level.

A host drops chip select and shifts in an instruction byte, MSB first. An address byte follows where the instruction needs one.

- Reads stream bytes from an auto-incrementing pointer.
- Writes fill a page buffer of up to eight bytes. The buffer is committed to the array when chip select rises.
- Each commit starts a self-timed busy period. The busy bit in the status byte reads 1 for its whole length.

Software protection uses a write-enable latch and two block-protect bits. The write-protect pin locks the protect bits against change. Holding the hold pin low pauses a transfer in the middle of a byte.

Top module: `spi_eeprom`

## Requirements
- R1: The block works in SPI mode 0 (SCK idles low) and mode 3 (SCK idles high). SI is captured on rising SCK edges and SO changes on falling SCK edges. Each SCK level must last at least 4 clk cycles.
- R2: The first byte of a frame is the instruction, shifted in MSB first: 0x06 sets write enable, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads and 0x02 writes. For read and write the next byte is the address, and its low 7 bits are used. An unknown instruction makes the rest of the frame have no effect.
- R3: A read returns the byte at the address and then successive bytes for as long as chip select stays low. The pointer wraps from 0x7F to 0x00.
- R4: The status byte has bit 0 = busy, bit 1 = write enable and bits 3:2 = protect level; the other bits read 0. Reading status repeats the current status byte while chip select stays low. After reset the status byte is 0x00 and every array byte is 0xFF.
- R5: A write or a status write has no effect unless the write-enable latch is set. 0x06 sets the latch and 0x04 clears it.
- R6: Data bytes of one write go to consecutive addresses within the 8-byte page of the start address. Past the page end they wrap to the start of that page.
- R7: A write or status write takes effect only when chip select rises after a whole number of data bytes, at least one. Otherwise the frame is discarded and the write-enable latch keeps its value.
- R8: An accepted write or status write makes the busy bit read 1 for BUSY_CYCLES clk cycles. When the busy period ends, the write-enable latch clears.
- R9: While busy, only the status read instruction is honoured. Any other frame is ignored and SO stays disabled.
- R10: Protect level 1 guards addresses 0x60-0x7F, level 2 guards 0x40-0x7F and level 3 guards the whole array. A write starting in a guarded page is discarded, starts no busy period and leaves the write-enable latch as it was.
- R11: While the write-protect pin is low, a status write is ignored and the protect level keeps its value.
- R12: While hold is low during a frame, SCK and SI are ignored and SO is disabled. After hold is released, the transfer continues from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for spi_so (0 = high impedance) |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_n | input | 1 | Hold pin, active low |

## Verification
The assertions check, on every cycle, four properties:
- the bit counter stays frozen while hold is low;
- the protect bits change only when the write-protect pin was high;
- the write-enable latch is clear once a busy period ends;
- no array write is ever issued while busy or with an empty byte mask.

Only the bench's scenarios can show the rest, because these are end-to-end data effects seen through later frames:
- page wrapping and sequential read wrapping;
- discarding of partial and unauthorised writes;
- protection of each address range;
- the exact byte recovered across a hold pause.

// File: rtl/spi_eeprom_pkg.sv
`timescale 1ns/1ps
package spi_eeprom_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_READ,
        ST_STAT,
        ST_SRDATA,
        ST_SKIP
    } frame_state_e;

    typedef struct packed {
        logic [1:0] lvl;
        logic       wel;
        logic       wip;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {4'b0000, s.lvl, s.wel, s.wip};
    endfunction

    // top2 = two most significant address bits of the target
    function automatic logic zone_locked(logic [1:0] lvl, logic [1:0] top2);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return top2 == 2'b11;
            2'd2:    return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eeprom_spi_shift.sv
`timescale 1ns/1ps
module eeprom_spi_shift
    import spi_eeprom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sck_s,
    input  logic             si_s,
    input  logic             hold_n_s,
    input  logic             tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic             byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic             aligned,
    output logic             so,
    output logic             so_oe
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] acc;
    logic [BYTE_W-1:0] tx_sr;
    logic              oe_r;
    logic              active, rise, fall;

    assign active  = !cs_n_s && hold_n_s;
    assign rise    = active && sck_s && !sck_q;
    assign fall    = active && !sck_s && sck_q;
    assign aligned = (cnt == '0);
    assign so_oe   = oe_r && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            cnt       <= '0;
            acc       <= '0;
            tx_sr     <= '0;
            so        <= 1'b0;
            oe_r      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sck_q     <= sck_s;
            byte_done <= 1'b0;
            if (cs_n_s) begin
                cnt  <= '0;
                oe_r <= 1'b0;
            end else begin
                if (rise) begin
                    acc <= {acc[BYTE_W-3:0], si_s};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(BYTE_W - 1)) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {acc, si_s};
                    end
                end
                if (fall) begin
                    if (aligned && tx_valid) begin
                        so    <= tx_byte[BYTE_W-1];
                        tx_sr <= {tx_byte[BYTE_W-2:0], 1'b0};
                        oe_r  <= 1'b1;
                    end else begin
                        so    <= tx_sr[BYTE_W-1];
                        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assert_hold_freezes_bits_R12: assert property (@(posedge clk) disable iff (rst)
        (!hold_n_s && !cs_n_s) |=> $stable(cnt));

endmodule

// File: rtl/eeprom_cells.sv
`timescale 1ns/1ps
module eeprom_cells
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [BYTE_W-1:0]                  rd_data,
    input  logic                               wr_en,
    input  logic [ADDR_W-PAGE_W-1:0]           wr_page,
    input  logic [(1<<PAGE_W)-1:0]             wr_mask,
    input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] wr_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            for (int c = 0; c < PAGE_N; c++) begin
                if (wr_mask[c]) mem[{wr_page, PAGE_W'(c)}] <= wr_data[c];
            end
        end
    end

    assert_no_empty_commit_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_mask != '0));

endmodule

// File: rtl/eeprom_ctrl.sv
`timescale 1ns/1ps
module eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYCLES = 625000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cs_n_s,
    input  logic                               wp_n_s,
    input  logic                               byte_done,
    input  logic [BYTE_W-1:0]                  rx_byte,
    input  logic                               aligned,
    input  logic [BYTE_W-1:0]                  rd_data,
    output logic                               tx_valid,
    output logic [BYTE_W-1:0]                  tx_byte,
    output logic [ADDR_W-1:0]                  rd_addr,
    output logic                               wr_en,
    output logic [ADDR_W-PAGE_W-1:0]           wr_page,
    output logic [(1<<PAGE_W)-1:0]             wr_mask,
    output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] wr_data
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

    frame_state_e       state;
    logic               op_rd;
    logic [ADDR_W-1:0]  ptr;
    logic [PG_W-1:0]    page;
    logic [PAGE_W-1:0]  col;
    logic [PAGE_N-1:0][BYTE_W-1:0] pg_data;
    logic [PAGE_N-1:0]  mask;
    logic               got;
    logic [1:0]         lvl_new;
    stat_t              st;
    logic [BCNT_W-1:0]  bcnt;
    logic               cs_q, cs_rise;
    logic               commit_w, commit_s;
    logic               unused_rx;

    assign unused_rx = ^rx_byte;
    assign cs_rise   = cs_n_s && !cs_q;
    assign commit_w  = cs_rise && state == ST_WDATA && got && aligned && st.wel && !st.wip
                       && !zone_locked(st.lvl, page[PG_W-1 -: 2]);
    assign commit_s  = cs_rise && state == ST_SRDATA && got && aligned && st.wel && !st.wip
                       && wp_n_s;

    assign wr_en    = commit_w;
    assign wr_page  = page;
    assign wr_mask  = mask;
    assign wr_data  = pg_data;
    assign rd_addr  = ptr;
    assign tx_valid = (state == ST_READ) || (state == ST_STAT);
    assign tx_byte  = (state == ST_STAT) ? stat_byte(st) : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OPC;
            op_rd   <= 1'b0;
            ptr     <= '0;
            page    <= '0;
            col     <= '0;
            pg_data <= '0;
            mask    <= '0;
            got     <= 1'b0;
            lvl_new <= '0;
            st      <= '0;
            bcnt    <= '0;
            cs_q    <= 1'b1;
        end else begin
            cs_q <= cs_n_s;
            if (st.wip) begin
                if (bcnt <= BCNT_W'(1)) begin
                    st.wip <= 1'b0;
                    st.wel <= 1'b0;
                end else begin
                    bcnt <= bcnt - 1'b1;
                end
            end
            if (commit_w || commit_s) begin
                st.wip <= 1'b1;
                bcnt   <= BCNT_W'(BUSY_CYCLES);
                if (commit_s) st.lvl <= lvl_new;
            end
            if (cs_n_s) begin
                state <= ST_OPC;
            end else if (byte_done) begin
                case (state)
                    ST_OPC: begin
                        got  <= 1'b0;
                        mask <= '0;
                        if (st.wip && rx_byte != OP_RDSR) begin
                            state <= ST_SKIP;
                        end else begin
                            case (rx_byte)
                                OP_WREN: begin st.wel <= 1'b1; state <= ST_SKIP; end
                                OP_WRDI: begin st.wel <= 1'b0; state <= ST_SKIP; end
                                OP_RDSR: state <= ST_STAT;
                                OP_WRSR: state <= ST_SRDATA;
                                OP_READ: begin op_rd <= 1'b1; state <= ST_ADDR; end
                                OP_WRIT: begin op_rd <= 1'b0; state <= ST_ADDR; end
                                default: state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        ptr   <= rx_byte[ADDR_W-1:0];
                        page  <= rx_byte[ADDR_W-1:PAGE_W];
                        col   <= rx_byte[PAGE_W-1:0];
                        state <= op_rd ? ST_READ : ST_WDATA;
                    end
                    ST_WDATA: begin
                        pg_data[col] <= rx_byte;
                        mask[col]    <= 1'b1;
                        col          <= col + 1'b1;
                        got          <= 1'b1;
                    end
                    ST_READ: ptr <= ptr + 1'b1;
                    ST_SRDATA: begin
                        lvl_new <= rx_byte[3:2];
                        got     <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_wel_clear_after_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(st.wip) |-> !st.wel);
    assert_no_commit_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
        st.wip |-> !wr_en);
    assert_lvl_locked_by_pin_R11: assert property (@(posedge clk) disable iff (rst)
        (st.lvl != $past(st.lvl)) |-> $past(wp_n_s));

endmodule

// File: rtl/spi_eeprom.sv
`timescale 1ns/1ps
module spi_eeprom
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe,
    input  logic wp_n,
    input  logic hold_n
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int PG_W   = ADDR_W - PAGE_W;

    logic cs_n_s, sck_s, si_s, wp_n_s, hold_n_s;
    logic byte_done, aligned, tx_valid, wr_en;
    logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [PG_W-1:0]   wr_page;
    logic [PAGE_N-1:0] wr_mask;
    logic [PAGE_N-1:0][BYTE_W-1:0] wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_s   <= 1'b1;
            sck_s    <= 1'b0;
            si_s     <= 1'b0;
            wp_n_s   <= 1'b1;
            hold_n_s <= 1'b1;
        end else begin
            cs_n_s   <= spi_cs_n;
            sck_s    <= spi_sck;
            si_s     <= spi_si;
            wp_n_s   <= wp_n;
            hold_n_s <= hold_n;
        end
    end

    eeprom_spi_shift u_shift (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s),
        .hold_n_s(hold_n_s), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .aligned(aligned),
        .so(spi_so), .so_oe(spi_so_oe)
    );

    eeprom_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .wp_n_s(wp_n_s),
        .byte_done(byte_done), .rx_byte(rx_byte), .aligned(aligned),
        .rd_data(rd_data), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_page(wr_page),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    eeprom_cells #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cells (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_page(wr_page), .wr_mask(wr_mask), .wr_data(wr_data)
    );

endmodule

// File: tb/spi_eeprom_test.sv
`timescale 1ns/1ps
module spi_eeprom_test;
    localparam int BUSY = 400;
    localparam int HALF = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe;

    int checks = 0, fails = 0;
    logic mode3 = 1'b0;
    logic oe_seen;
    int cs_hi = 0;

    logic [7:0] ref_mem [128];
    logic       ref_wel = 1'b0;
    logic [1:0] ref_lvl = 2'd0;

    spi_eeprom #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .wp_n(wp_n), .hold_n(hold_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison: with chip select idle the output must be off (R12/R9 path)
    always @(negedge clk) begin
        if (so_oe) oe_seen = 1'b1;
        cs_hi = cs_n ? cs_hi + 1 : 0;
        if (!rst && cs_hi >= 2) chk("R12 idle SO disabled", so_oe, 0);
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic begin_frame();
        sck = mode3;
        wclk(2);
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic end_frame();
        sck = mode3;
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         input int nbits, input int hold_at);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sck = 1'b0;
            si  = tx[i];
            if (hold_at == i) begin
                wclk(2);
                hold_n = 1'b0;
                wclk(3);
                chk("R12 SO off in hold", so_oe, 0);
                sck = 1'b1; si = ~si; wclk(HALF);
                sck = 1'b0; si = tx[i]; wclk(HALF);
                hold_n = 1'b1;
                wclk(2);
            end
            wclk(HALF);
            rx[i] = so;
            sck = 1'b1;
            wclk(HALF);
        end
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        begin_frame();
        xbyte(8'h05, r, 8, -1);
        xbyte(8'h00, s, 8, -1);
        end_frame();
    endtask

    task automatic simple(input logic [7:0] op);
        logic [7:0] r;
        begin_frame();
        xbyte(op, r, 8, -1);
        end_frame();
        if (op == 8'h06) ref_wel = 1'b1;
        if (op == 8'h04) ref_wel = 1'b0;
    endtask

    function automatic logic locked(input logic [1:0] l, input logic [6:0] a);
        if (l == 2'd1) return a >= 7'h60;
        if (l == 2'd2) return a >= 7'h40;
        return l == 2'd3;
    endfunction

    task automatic wait_idle();
        logic [7:0] s;
        rdsr(s);
        chk("R8 busy bit set after commit", s[0], 1);
        for (int k = 0; k < 40 && s[0]; k++) rdsr(s);
        ref_wel = 1'b0;
        chk("R8 idle status with latch cleared", s, {4'b0, ref_lvl, 2'b00});
    endtask

    task automatic write_pg(input logic [6:0] a, input logic [7:0] d [8],
                            input int n, input int extra, output logic ok);
        logic [7:0] r;
        begin_frame();
        xbyte(8'h02, r, 8, -1);
        xbyte({1'b0, a}, r, 8, -1);
        for (int k = 0; k < n; k++) xbyte(d[k], r, 8, -1);
        if (extra > 0) xbyte(8'hA5, r, extra, -1);
        end_frame();
        ok = ref_wel && n > 0 && extra == 0 && !locked(ref_lvl, a);
        if (ok)
            for (int k = 0; k < n; k++)
                ref_mem[(a & 7'h78) | ((a + 7'(k)) & 7'h07)] = d[k];
    endtask

    task automatic wrsr(input logic [7:0] v, output logic ok);
        logic [7:0] r;
        begin_frame();
        xbyte(8'h01, r, 8, -1);
        xbyte(v, r, 8, -1);
        end_frame();
        ok = ref_wel && wp_n;
        if (ok) ref_lvl = v[3:2];
    endtask

    task automatic read_chk(input logic [6:0] a, input int n,
                            input string req, input int hold_at);
        logic [7:0] r;
        begin_frame();
        xbyte(8'h03, r, 8, -1);
        xbyte({1'b0, a}, r, 8, -1);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r, 8, (k == 0) ? hold_at : -1);
            chk(req, r, ref_mem[7'(a + 7'(k))]);
        end
        end_frame();
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, r;
        logic ok;
        logic [7:0] d [8];
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        wclk(10);
        rst = 1'b0;
        wclk(3);

        chk("R4 SO off after reset", so_oe, 0);
        rdsr(s);
        chk("R4 status after reset", s, 8'h00);
        read_chk(7'h00, 2, "R4 erased array", -1);

        // R5: write without the latch is ignored
        d = '{8'hAA, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h10, d, 1, 0, ok);
        rdsr(s);
        chk("R5 no busy without latch", s, 8'h00);
        read_chk(7'h10, 1, "R5 byte untouched", -1);
        simple(8'h06);
        rdsr(s);
        chk("R5 latch set", s, 8'h02);
        simple(8'h04);
        rdsr(s);
        chk("R5 latch cleared", s, 8'h00);

        // R6/R8/R9: page write, read attempt while busy
        simple(8'h06);
        d = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
        write_pg(7'h10, d, 3, 0, ok);
        oe_seen = 1'b0;
        begin_frame();
        xbyte(8'h03, r, 8, -1);
        xbyte(8'h10, r, 8, -1);
        xbyte(8'h00, r, 8, -1);
        end_frame();
        chk("R9 read ignored while busy", oe_seen, 0);
        wait_idle();
        read_chk(7'h10, 4, "R3 sequential read after R6 write", -1);

        // R1 mode 3 with page wrap R6
        mode3 = 1'b1;
        simple(8'h06);
        d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 0, 0, 0, 0};
        write_pg(7'h1E, d, 4, 0, ok);
        wait_idle();
        read_chk(7'h18, 9, "R6 page wrap in mode 3 (R1)", -1);
        mode3 = 1'b0;

        // R7: partial trailing byte discards the frame
        simple(8'h06);
        d = '{8'h5C, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h30, d, 1, 3, ok);
        rdsr(s);
        chk("R7 no busy, latch kept", s, 8'h02);
        read_chk(7'h30, 1, "R7 partial write discarded", -1);
        simple(8'h04);

        // R3: wrap of the read pointer
        simple(8'h06);
        d = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h7F, d, 1, 0, ok);
        wait_idle();
        simple(8'h06);
        d = '{8'hC3, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h00, d, 1, 0, ok);
        wait_idle();
        read_chk(7'h7E, 3, "R3 pointer wrap", -1);

        // R10: protection levels
        simple(8'h06);
        wrsr(8'h04, ok);
        wait_idle();
        simple(8'h06);
        d = '{8'h77, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h70, d, 1, 0, ok);
        rdsr(s);
        chk("R10 guarded write no busy", s, 8'h06);
        d = '{8'h55, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h50, d, 1, 0, ok);
        wait_idle();
        read_chk(7'h70, 1, "R10 level 1 guards 0x70", -1);
        read_chk(7'h50, 1, "R10 level 1 allows 0x50", -1);
        simple(8'h06);
        wrsr(8'h08, ok);
        wait_idle();
        simple(8'h06);
        d = '{8'h66, 0, 0, 0, 0, 0, 0, 0};
        write_pg(7'h50, d, 1, 0, ok);
        read_chk(7'h50, 1, "R10 level 2 guards 0x50", -1);

        // R11: pin locks the protect level
        wp_n = 1'b0;
        wrsr(8'h00, ok);
        rdsr(s);
        chk("R11 level kept with pin low", s, 8'h0A);
        wp_n = 1'b1;
        wrsr(8'h00, ok);
        wait_idle();
        rdsr(s);
        chk("R11 level changes with pin high", s, 8'h00);

        // R12: hold in the middle of a data byte
        read_chk(7'h10, 2, "R12 byte intact across hold", 4);

        // R2: unknown instruction has no effect
        oe_seen = 1'b0;
        begin_frame();
        xbyte(8'hFF, r, 8, -1);
        xbyte(8'h10, r, 8, -1);
        xbyte(8'h00, r, 8, -1);
        end_frame();
        chk("R2 unknown opcode no output", oe_seen, 0);
        rdsr(s);
        chk("R2 unknown opcode status", s, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule